// File: doc/BRIEF.md
# Fuse Range Check-Word Generator

This engine walks a fixed window of the fuse array and condenses it into a 14-bit Hamming-style check word. A single start pulse launches a run. The engine fetches the rows that cover the window, lowest row first, over a row-read port that uses a request/valid handshake. It then examines each fetched word one bit per clock, from bit 0 up to the top bit.

A position counter begins at 0x7FF and advances by one just before every bit is examined. This includes bits of the first and last rows that fall outside the window. For each set bit inside the window, the current counter value is folded into an accumulator by XOR. When the last row is done, the engine forms the result from three parts:

- the accumulator,
- a constant marker at bit 12,
- the inverse of the accumulator's overall parity at bit 13.

It then raises a one-cycle done pulse and holds the result until the next run finishes. The window bounds, the row width, the counter seed and the bit positions of the marker and parity are parameters. By default the window covers absolute bits 2167 to 3326 inclusive, which spans rows 67 to 103.

Top module: `fuse_hcode_gen`

## Requirements
- R1: After reset, the request output, the done output and the whole result are all 0.
- R2: A run requests each row from 67 (2167/32) to 103 (3326/32) exactly once, in ascending order, and requests no row outside that span.
- R3: A row request stays high with a stable row number until the port answers with valid. A data word is taken only in a cycle where request and valid are both high. A valid with no request pending has no effect on the result.
- R4: The scan position k counts from 0 at bit 0 of row 67 and rises by one for every bit of every fetched row, skipped bits included. The bit at position k carries the counter value 0x800 + k (0x7FF advanced once).
- R5: A bit contributes only if its absolute index row*32 + bit lies within 2167..3326. Set bits 0..22 of row 67, bit 31 of row 103, and bits of any other row leave the result unchanged.
- R6: The result equals acc | (1 << 12) | ((~^acc) << 13), where acc is the XOR of the counter values of all contributing set bits. With no contributing bits the result is 0x00003000.
- R7: Each run raises done for exactly one cycle. The result changes only in the cycle done goes high and holds its value afterwards.
- R8: A start pulse that arrives while a run is in progress is ignored. It neither restarts the scan, adds requests, nor produces an extra done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that launches a run when idle |
| rd_req_o | output | 1 | Row read request, held until answered |
| rd_row_o | output | 8 | Row number being requested |
| rd_valid_i | input | 1 | Row data valid; completes a pending request |
| rd_data_i | input | 32 | Row data word |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| result_o | output | 32 | Check word, held between runs |

## Verification
Two pairs of events can coincide with a run in progress. The first is a fresh start pulse landing in the middle of the scan. The second is a valid strobe arriving while no request is pending, with the data bus carrying all ones.

The bench provokes both. It pulses start a few hundred cycles into a run, and it drives spurious all-ones valid strobes at random between requests.

A run passes only if all of the following hold:
- the handshake log shows each row 67 through 103 exactly once, in order;
- exactly one done pulse appears;
- the result matches a model computed in the bench from the stored rows.

An all-zero array with spurious strobes enabled must still yield 0x3000.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_SCAN  = 2'd2,
      ST_SEAL  = 2'd3
   } fhc_state_e;
endpackage

// File: rtl/fhc_ctrl.sv
module fhc_ctrl
   import fhc_pkg::*;
#(
   parameter int ROW_AW    = 8,
   parameter int FIRST_ROW = 67,
   parameter int LAST_ROW  = 103
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_valid_i,
   input  logic              row_end_i,
   output logic [ROW_AW-1:0] row_o,
   output logic              rd_req_o,
   output logic              clear_o,
   output logic              load_o,
   output logic              step_o,
   output logic              seal_o
);
   fhc_state_e        state_q;
   logic [ROW_AW-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               row_q   <= ROW_AW'(FIRST_ROW);
               state_q <= ST_FETCH;
            end
            ST_FETCH: if (rd_valid_i) state_q <= ST_SCAN;
            ST_SCAN: if (row_end_i) begin
               if (row_q == ROW_AW'(LAST_ROW)) begin
                  state_q <= ST_SEAL;
               end else begin
                  row_q   <= row_q + ROW_AW'(1);
                  state_q <= ST_FETCH;
               end
            end
            ST_SEAL: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign row_o    = row_q;
   assign rd_req_o = (state_q == ST_FETCH);
   assign clear_o  = (state_q == ST_IDLE) && start_i;
   assign load_o   = (state_q == ST_FETCH) && rd_valid_i;
   assign step_o   = (state_q == ST_SCAN);
   assign seal_o   = (state_q == ST_SEAL);
endmodule

// File: rtl/fhc_walk.sv
module fhc_walk #(
   parameter int          ROW_W     = 32,
   parameter int          ROW_AW    = 8,
   parameter int          ACC_W     = 32,
   parameter int          FIRST_BIT = 2167,
   parameter int          LAST_BIT  = 3326,
   parameter logic [31:0] PAT_INIT  = 32'h0000_07FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [ROW_AW-1:0] row_i,
   input  logic [ROW_W-1:0]  data_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic              row_end_o
);
   localparam int BIT_AW = $clog2(ROW_W);
   localparam int ABS_W  = ROW_AW + BIT_AW;

   logic [ROW_W-1:0]  word_q;
   logic [BIT_AW-1:0] bit_q;
   logic [ACC_W-1:0]  pat_q, pat_nx, acc_q;
   logic [ABS_W-1:0]  abs_idx;
   logic              in_window, hit;

   assign pat_nx    = pat_q + ACC_W'(1);
   assign abs_idx   = {row_i, bit_q};
   assign in_window = (abs_idx >= ABS_W'(FIRST_BIT)) && (abs_idx <= ABS_W'(LAST_BIT));
   assign hit       = in_window && word_q[bit_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         bit_q  <= '0;
         pat_q  <= '0;
         acc_q  <= '0;
      end else if (clear_i) begin
         pat_q <= ACC_W'(PAT_INIT);
         acc_q <= '0;
      end else if (load_i) begin
         word_q <= data_i;
         bit_q  <= '0;
      end else if (step_i) begin
         pat_q <= pat_nx;
         bit_q <= bit_q + BIT_AW'(1);
         if (hit) acc_q <= acc_q ^ pat_nx;
      end
   end

   assign acc_o     = acc_q;
   assign row_end_o = (bit_q == BIT_AW'(ROW_W - 1));
endmodule

// File: rtl/fhc_seal.sv
module fhc_seal #(
   parameter int ACC_W      = 32,
   parameter int RES_W      = 32,
   parameter int MARK_POS   = 12,
   parameter int PAR_POS    = 13,
   parameter bit PAR_INVERT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seal_i,
   input  logic [ACC_W-1:0] acc_i,
   output logic [RES_W-1:0] result_o,
   output logic             done_o
);
   logic             par_bit;
   logic [RES_W-1:0] sealed, mark_vec, par_vec;

   generate
      if (PAR_INVERT) begin : g_par_inv
         assign par_bit = ~(^acc_i);
      end else begin : g_par_true
         assign par_bit = ^acc_i;
      end
   endgenerate

   always_comb begin
      mark_vec           = '0;
      mark_vec[MARK_POS] = 1'b1;
      par_vec            = '0;
      par_vec[PAR_POS]   = par_bit;
      sealed             = RES_W'(acc_i) | mark_vec | par_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= seal_i;
         if (seal_i) result_o <= sealed;
      end
   end
endmodule

// File: rtl/fuse_hcode_gen.sv
module fuse_hcode_gen #(
   parameter int          ROW_W      = 32,
   parameter int          ROW_AW     = 8,
   parameter int          ACC_W      = 32,
   parameter int          RES_W      = 32,
   parameter int          FIRST_BIT  = 2167,
   parameter int          LAST_BIT   = 3326,
   parameter logic [31:0] PAT_INIT   = 32'h0000_07FF,
   parameter int          MARK_POS   = 12,
   parameter int          PAR_POS    = 13,
   parameter bit          PAR_INVERT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rd_req_o,
   output logic [ROW_AW-1:0] rd_row_o,
   input  logic              rd_valid_i,
   input  logic [ROW_W-1:0]  rd_data_i,
   output logic              done_o,
   output logic [RES_W-1:0]  result_o
);
   localparam int FIRST_ROW = FIRST_BIT / ROW_W;
   localparam int LAST_ROW  = LAST_BIT / ROW_W;

   if ((1 << $clog2(ROW_W)) != ROW_W) begin : g_bad_row_w
      $error("ROW_W must be a power of two");
   end
   if (LAST_BIT < FIRST_BIT) begin : g_bad_window
      $error("window bounds reversed");
   end
   if (LAST_ROW >= (1 << ROW_AW)) begin : g_bad_row_aw
      $error("ROW_AW too narrow for window");
   end
   if (ACC_W > RES_W || MARK_POS >= RES_W || PAR_POS >= RES_W || MARK_POS == PAR_POS) begin : g_bad_res
      $error("result layout inconsistent");
   end

   logic clear, load, step, seal, row_end;
   logic [ACC_W-1:0] acc;

   fhc_ctrl #(
      .ROW_AW(ROW_AW), .FIRST_ROW(FIRST_ROW), .LAST_ROW(LAST_ROW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_valid_i(rd_valid_i),
      .row_end_i(row_end), .row_o(rd_row_o), .rd_req_o(rd_req_o),
      .clear_o(clear), .load_o(load), .step_o(step), .seal_o(seal)
   );

   fhc_walk #(
      .ROW_W(ROW_W), .ROW_AW(ROW_AW), .ACC_W(ACC_W),
      .FIRST_BIT(FIRST_BIT), .LAST_BIT(LAST_BIT), .PAT_INIT(PAT_INIT)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .load_i(load), .step_i(step),
      .row_i(rd_row_o), .data_i(rd_data_i), .acc_o(acc), .row_end_o(row_end)
   );

   fhc_seal #(
      .ACC_W(ACC_W), .RES_W(RES_W), .MARK_POS(MARK_POS),
      .PAR_POS(PAR_POS), .PAR_INVERT(PAR_INVERT)
   ) u_seal (
      .clk(clk), .rst_n(rst_n), .seal_i(seal), .acc_i(acc),
      .result_o(result_o), .done_o(done_o)
   );
endmodule

// File: rtl/fhc_chk.sv
module fhc_chk #(
   parameter int ROW_AW     = 8,
   parameter int RES_W      = 32,
   parameter int FIRST_ROW  = 67,
   parameter int LAST_ROW   = 103,
   parameter int MARK_POS   = 12,
   parameter int PAR_POS    = 13,
   parameter bit PAR_INVERT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_o,
   input logic [ROW_AW-1:0] rd_row_o,
   input logic              rd_valid_i,
   input logic              done_o,
   input logic [RES_W-1:0]  result_o
);
   logic [RES_W-1:0] data_mask;
   always_comb begin
      data_mask           = '1;
      data_mask[MARK_POS] = 1'b0;
      data_mask[PAR_POS]  = 1'b0;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_row_o))); // R3
   AST_ROW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_row_o >= ROW_AW'(FIRST_ROW) && rd_row_o <= ROW_AW'(LAST_ROW))); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> done_o); // R7
   AST_MARKER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> result_o[MARK_POS]); // R6
   AST_PARITY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o[PAR_POS] == (PAR_INVERT ^ (^(result_o & data_mask))))); // R6
endmodule

bind fuse_hcode_gen fhc_chk #(
   .ROW_AW(ROW_AW), .RES_W(RES_W),
   .FIRST_ROW(FIRST_BIT / ROW_W), .LAST_ROW(LAST_BIT / ROW_W),
   .MARK_POS(MARK_POS), .PAR_POS(PAR_POS), .PAR_INVERT(PAR_INVERT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req_o(rd_req_o), .rd_row_o(rd_row_o),
   .rd_valid_i(rd_valid_i), .done_o(done_o), .result_o(result_o)
);

// File: tb/tb_fuse_hcode_gen.sv
module tb_fuse_hcode_gen;
   localparam int FIRST_BIT = 2167;
   localparam int LAST_BIT  = 3326;
   localparam int FIRST_ROW = FIRST_BIT / 32;
   localparam int LAST_ROW  = LAST_BIT / 32;
   localparam int N_ROWS    = LAST_ROW - FIRST_ROW + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_req_o;
   logic [7:0]  rd_row_o;
   logic        rd_valid_i = 1'b0;
   logic [31:0] rd_data_i = '0;
   logic        done_o;
   logic [31:0] result_o;

   always #2 clk = ~clk;

   fuse_hcode_gen dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
      .rd_row_o(rd_row_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
      .done_o(done_o), .result_o(result_o)
   );

   logic [31:0] mem [0:255];
   int n_chk = 0, n_fail = 0;
   int lat_cnt = 0, lat_tgt = 0, max_lat = 0;
   bit spurious_en = 1'b0;
   int hs_cnt = 0, done_cnt = 0;
   logic [7:0] hs_rows [0:63];
   int cyc = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
      end
   endtask

   // fuse array model: answers requests after a random latency, may strobe valid with no request
   always @(negedge clk) begin
      if (done_o) done_cnt++;
      if (rd_valid_i) begin
         rd_valid_i = 1'b0;
      end else if (rd_req_o) begin
         if (lat_cnt >= lat_tgt) begin
            rd_valid_i = 1'b1;
            rd_data_i  = mem[rd_row_o];
            if (hs_cnt < 64) hs_rows[hs_cnt] = rd_row_o;
            hs_cnt++;
            lat_cnt = 0;
            lat_tgt = $urandom_range(0, max_lat);
         end else begin
            lat_cnt++;
         end
      end else if (spurious_en && $urandom_range(0, 5) == 0) begin
         rd_valid_i = 1'b1;
         rd_data_i  = 32'hFFFF_FFFF;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic logic [31:0] model_code();
      logic [31:0] acc = '0;
      logic [31:0] pat = 32'h7FF;
      for (int r = FIRST_ROW; r <= LAST_ROW; r++) begin
         for (int b = 0; b < 32; b++) begin
            int idx;
            pat = pat + 1;
            idx = r * 32 + b;
            if (idx >= FIRST_BIT && idx <= LAST_BIT && mem[r][b]) acc = acc ^ pat;
         end
      end
      return acc | 32'h1000 | ({31'd0, ~(^acc)} << 13);
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = '0;
   endtask

   task automatic run(input bit mid_start, input string tag, input logic [31:0] exp);
      logic [31:0] got;
      bit ord_ok;
      hs_cnt   = 0;
      done_cnt = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (mid_start) begin
         repeat (300) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      got = result_o;
      chk(got == exp, tag, got, exp);
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done width", {31'd0, done_o}, 32'd0);
      repeat (6) @(negedge clk);
      chk(result_o == got, "R7 result hold", result_o, got);
      chk(done_cnt == 1, mid_start ? "R8 single done" : "R7 single done", done_cnt, 1);
      chk(hs_cnt == N_ROWS, mid_start ? "R8 request count" : "R2 request count", hs_cnt, N_ROWS);
      ord_ok = 1'b1;
      for (int i = 0; i < N_ROWS && i < 64; i++)
         if (hs_rows[i] != 8'(FIRST_ROW + i)) ord_ok = 1'b0;
      chk(ord_ok, "R2 row order", {31'd0, ord_ok}, 32'd1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      clear_mem();
      repeat (4) @(negedge clk);
      chk(rd_req_o == 1'b0, "R1 req", {31'd0, rd_req_o}, 32'd0);
      chk(done_o == 1'b0, "R1 done", {31'd0, done_o}, 32'd0);
      chk(result_o == 32'd0, "R1 result", result_o, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rd_req_o == 1'b0 && result_o == 32'd0, "R1 idle after reset", result_o, 32'd0);

      // R6: empty array gives marker plus inverted zero parity
      run(1'b0, "R6 empty", 32'h0000_3000);

      // R3: spurious all-ones valid strobes between requests must not leak in
      spurious_en = 1'b1;
      max_lat = 3;
      run(1'b0, "R3 spurious valid", 32'h0000_3000);

      // R5: only bits just outside the window and in neighbour rows set
      clear_mem();
      mem[FIRST_ROW] = 32'h007F_FFFF;
      mem[LAST_ROW]  = 32'h8000_0000;
      mem[FIRST_ROW - 1] = 32'hFFFF_FFFF;
      mem[LAST_ROW + 1]  = 32'hFFFF_FFFF;
      run(1'b0, "R5 outside window", 32'h0000_3000);

      // R4: first in-window bit sits at scan position 23 -> 0x817, odd parity
      clear_mem();
      mem[FIRST_ROW] = 32'h0080_0000;
      run(1'b0, "R4 first bit", 32'h0000_1817);

      // R4 R5: last in-window bit at position 1182 -> 0xC9E, odd parity
      clear_mem();
      mem[LAST_ROW] = 32'h4000_0000;
      run(1'b0, "R5 last bit", 32'h0000_1C9E);

      // random arrays against the bench model
      for (int t = 0; t < 5; t++) begin
         for (int i = 0; i < 256; i++) mem[i] = $urandom;
         max_lat = t % 4;
         run(1'b0, "R6 random", model_code());
      end

      // R8: restart attempt during a run
      for (int i = 0; i < 256; i++) mem[i] = $urandom;
      run(1'b1, "R8 mid-run start", model_code());

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule